// File: doc/BRIEF.md
# Decode Group Controller with Stall Replay

This block sequences the combined fetch and decode stage of an out-of-order core. In each cycle it offers up to `WIDTH` instructions, in program order, to the dispatch logic. It holds the PC/NPC pair and a running instruction tag. For every candidate position it drives a fetch address and takes back region-hit flags, instruction words and a branch prediction. For each candidate it picks one of three sources: the application image, the trap table (only in privileged mode), or a synthesized illegal-PC instruction.

Dispatch accepts any prefix of the offered slots. The first valid slot that is refused goes into a one-entry replay holder, and nothing behind it is decoded. In the next cycle the held instruction is offered again in slot 0, ahead of any new work. A predicted-taken branch or an illegal-PC instruction closes the group. After an illegal-PC instruction, decode stays quiet until a flush redirects the PC.

Top module: `decode_group_ctrl`

## Requirements
- R1: While the replay holder is occupied, its instruction is presented in slot 0 with its original PC, word and tag, ahead of newly decoded ones, and it stays there until slot 0 is accepted.
- R2: Dispatch consumes a valid slot only when it and every lower slot are accepted. The first refused valid slot that is a new instruction is captured by the holder, no slot behind it is decoded, and `stall_o` reads 1 in the next cycle.
- R3: At most `WIDTH` slots are valid per cycle, valid slots form a contiguous run from slot 0, and consumed instructions appear in program order.
- R4: A candidate whose `app_hit_i` bit is 1 carries its `app_insn_i` word and has `disp_ill_o` at 0.
- R5: A candidate without an application hit, in privileged mode (`priv_i`=1), with its `trap_hit_i` bit at 1, carries its `trap_insn_i` word.
- R6: Any other candidate becomes an illegal-PC instruction with `disp_ill_o`=1 and word `ILL_WORD` (all zeros by default). No slot after it is valid, and once it is decoded no slot is valid until a flush.
- R7: After a candidate that is neither a taken branch nor illegal, the next PC is its NPC and the next NPC is that value plus `STEP`.
- R8: A candidate with its `pred_taken_i` bit at 1 ends the group: no later slot is valid that cycle, and decode resumes at `pred_target_i` with NPC equal to target plus `STEP`.
- R9: Tags start at 0 after reset and rise by one for each decoded instruction; valid slots carry consecutive tags.
- R10: While `flush_i` is 1 no slot is valid. In the next cycle the holder is empty, the halt after an illegal PC is lifted, and candidate 0 fetches from `flush_pc_i` with NPC `flush_npc_i`.
- R11: During reset no slot is valid, `stall_o` is 0 and candidate 0 fetches from `RESET_PC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Redirect request, discards the holder |
| flush_pc_i | input | AW | PC after a flush |
| flush_npc_i | input | AW | NPC after a flush |
| priv_i | input | 1 | Privileged mode, enables trap-table source |
| fetch_pc_o | output | WIDTH*AW | Fetch address per candidate |
| app_hit_i | input | WIDTH | Candidate address lies in the application region |
| app_insn_i | input | WIDTH*IW | Application word per candidate |
| trap_hit_i | input | WIDTH | Candidate address hits a valid trap-table entry |
| trap_insn_i | input | WIDTH*IW | Trap-table word per candidate |
| pred_taken_i | input | WIDTH | Candidate predicted as a taken branch |
| pred_target_i | input | WIDTH*AW | Predicted target per candidate |
| disp_valid_o | output | WIDTH | Slot carries an instruction |
| disp_pc_o | output | WIDTH*AW | Slot PC |
| disp_insn_o | output | WIDTH*IW | Slot instruction word |
| disp_tag_o | output | WIDTH*TW | Slot instruction tag |
| disp_ill_o | output | WIDTH | Slot is an illegal-PC instruction |
| disp_accept_i | input | WIDTH | Dispatch takes the slot |
| stall_o | output | 1 | Replay holder occupied |

## Verification
The bench builds the block with `WIDTH`=3, a 16-bit PC, 32-bit words, 8-bit tags and `STEP`=4. Three slots are wide enough to show a replayed instruction in slot 0 with new work behind it in slots 1 and 2, a refusal in a middle slot, and a taken branch that cuts a group short. The small address and tag widths keep the application region, the trap window and a full run to an illegal PC within a few dozen cycles.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
   // Where a candidate instruction word comes from
   typedef enum logic [1:0] {
      SRC_APP  = 2'd0,
      SRC_TRAP = 2'd1,
      SRC_ILL  = 2'd2
   } src_e;
endpackage

// File: rtl/dgc_src_sel.sv
module dgc_src_sel
   import dgc_pkg::*;
#(
   parameter int              IW       = 32,
   parameter logic [IW-1:0]   ILL_WORD = '0
) (
   input  logic          app_hit_i,
   input  logic          trap_hit_i,
   input  logic          priv_i,
   input  logic [IW-1:0] app_insn_i,
   input  logic [IW-1:0] trap_insn_i,
   output src_e          src_o,
   output logic [IW-1:0] insn_o
);
   // Application image wins; trap table only in privileged mode
   always_comb begin
      if (app_hit_i)                src_o = SRC_APP;
      else if (priv_i && trap_hit_i) src_o = SRC_TRAP;
      else                          src_o = SRC_ILL;
   end

   always_comb begin
      case (src_o)
         SRC_APP:  insn_o = app_insn_i;
         SRC_TRAP: insn_o = trap_insn_i;
         default:  insn_o = ILL_WORD;
      endcase
   end
endmodule

// File: rtl/dgc_replay.sv
module dgc_replay #(
   parameter int AW = 32,
   parameter int IW = 32,
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          load_i,
   input  logic          rel_i,
   input  logic [AW-1:0] ld_pc_i,
   input  logic [IW-1:0] ld_insn_i,
   input  logic [TW-1:0] ld_tag_i,
   input  logic          ld_ill_i,
   output logic          valid_o,
   output logic [AW-1:0] pc_o,
   output logic [IW-1:0] insn_o,
   output logic [TW-1:0] tag_o,
   output logic          ill_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)       valid_o <= 1'b0;
      else if (clear_i) valid_o <= 1'b0;
      else if (load_i)  valid_o <= 1'b1;
      else if (rel_i)   valid_o <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_o   <= '0;
         insn_o <= '0;
         tag_o  <= '0;
         ill_o  <= 1'b0;
      end else if (load_i && !clear_i) begin
         pc_o   <= ld_pc_i;
         insn_o <= ld_insn_i;
         tag_o  <= ld_tag_i;
         ill_o  <= ld_ill_i;
      end
   end

   AST_REPLAY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clear_i) |=> (valid_o && pc_o == $past(ld_pc_i) && tag_o == $past(ld_tag_i))); // R2
   AST_REPLAY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !rel_i && !load_i && !clear_i) |=> (valid_o && $stable(tag_o) && $stable(pc_o))); // R1
   AST_REPLAY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !valid_o); // R10
endmodule

// File: rtl/dgc_slot_map.sv
module dgc_slot_map #(
   parameter int W  = 4,
   parameter int AW = 32,
   parameter int IW = 32,
   parameter int TW = 16,
   localparam int CNTW = $clog2(W + 1),
   localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
   input  logic                  gate_i,
   input  logic                  hold_valid_i,
   input  logic [AW-1:0]         hold_pc_i,
   input  logic [IW-1:0]         hold_insn_i,
   input  logic [TW-1:0]         hold_tag_i,
   input  logic                  hold_ill_i,
   input  logic [W-1:0]          c_live_i,
   input  logic [W-1:0][AW-1:0]  c_pc_i,
   input  logic [W-1:0][IW-1:0]  c_insn_i,
   input  logic [W-1:0][TW-1:0]  c_tag_i,
   input  logic [W-1:0]          c_ill_i,
   input  logic [W-1:0]          accept_i,
   output logic [W-1:0]          s_valid_o,
   output logic [W-1:0][AW-1:0]  s_pc_o,
   output logic [W-1:0][IW-1:0]  s_insn_o,
   output logic [W-1:0][TW-1:0]  s_tag_o,
   output logic [W-1:0]          s_ill_o,
   output logic                  rel_o,
   output logic                  load_o,
   output logic [IDXW-1:0]       ld_idx_o,
   output logic [CNTW-1:0]       ndec_o
);
   logic [W-1:0] from_hold;
   int           cidx [W];

   // Slot 0 belongs to the holder when it is occupied; new work shifts up
   always_comb begin
      for (int s = 0; s < W; s++) begin
         if (hold_valid_i && s == 0) begin
            from_hold[s] = 1'b1;
            cidx[s]      = 0;
            s_valid_o[s] = gate_i;
            s_pc_o[s]    = hold_pc_i;
            s_insn_o[s]  = hold_insn_i;
            s_tag_o[s]   = hold_tag_i;
            s_ill_o[s]   = hold_ill_i;
         end else begin
            from_hold[s] = 1'b0;
            cidx[s]      = hold_valid_i ? s - 1 : s;
            s_valid_o[s] = gate_i && c_live_i[cidx[s]];
            s_pc_o[s]    = c_pc_i[cidx[s]];
            s_insn_o[s]  = c_insn_i[cidx[s]];
            s_tag_o[s]   = c_tag_i[cidx[s]];
            s_ill_o[s]   = c_ill_i[cidx[s]];
         end
      end
   end

   // Prefix acceptance: the first refusal stops everything behind it
   always_comb begin
      logic ok;
      ok       = 1'b1;
      rel_o    = 1'b0;
      load_o   = 1'b0;
      ld_idx_o = '0;
      ndec_o   = '0;
      for (int s = 0; s < W; s++) begin
         if (s_valid_o[s] && ok) begin
            if (accept_i[s]) begin
               if (from_hold[s]) rel_o = 1'b1;
               else              ndec_o = ndec_o + CNTW'(1);
            end else begin
               ok = 1'b0;
               if (!from_hold[s]) begin
                  load_o   = 1'b1;
                  ld_idx_o = IDXW'(cidx[s]);
                  ndec_o   = ndec_o + CNTW'(1);
               end
            end
         end
      end
   end
endmodule

// File: rtl/decode_group_ctrl.sv
module decode_group_ctrl
   import dgc_pkg::*;
#(
   parameter int            WIDTH    = 4,
   parameter int            AW       = 32,
   parameter int            IW       = 32,
   parameter int            TW       = 16,
   parameter int            STEP     = 4,
   parameter logic [AW-1:0] RESET_PC = '0,
   parameter logic [IW-1:0] ILL_WORD = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush_i,
   input  logic [AW-1:0]         flush_pc_i,
   input  logic [AW-1:0]         flush_npc_i,
   input  logic                  priv_i,
   output logic [WIDTH*AW-1:0]   fetch_pc_o,
   input  logic [WIDTH-1:0]      app_hit_i,
   input  logic [WIDTH*IW-1:0]   app_insn_i,
   input  logic [WIDTH-1:0]      trap_hit_i,
   input  logic [WIDTH*IW-1:0]   trap_insn_i,
   input  logic [WIDTH-1:0]      pred_taken_i,
   input  logic [WIDTH*AW-1:0]   pred_target_i,
   output logic [WIDTH-1:0]      disp_valid_o,
   output logic [WIDTH*AW-1:0]   disp_pc_o,
   output logic [WIDTH*IW-1:0]   disp_insn_o,
   output logic [WIDTH*TW-1:0]   disp_tag_o,
   output logic [WIDTH-1:0]      disp_ill_o,
   input  logic [WIDTH-1:0]      disp_accept_i,
   output logic                  stall_o
);
   localparam int CNTW = $clog2(WIDTH + 1);
   localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   // Elaboration-time configuration checks
   if (WIDTH < 1) begin : g_bad_width
      $error("decode_group_ctrl: WIDTH must be at least 1");
   end
   if (STEP < 1) begin : g_bad_step
      $error("decode_group_ctrl: STEP must be positive");
   end
   if (TW < $clog2(WIDTH + 1)) begin : g_bad_tag
      $error("decode_group_ctrl: TW too narrow for WIDTH");
   end

   // Architectural state
   logic [AW-1:0] pc_q, npc_q;
   logic [TW-1:0] tag_q;
   logic          halt_q;

   // Packed views of the per-candidate ports
   logic [WIDTH-1:0][IW-1:0] app_v, trap_v;
   logic [WIDTH-1:0][AW-1:0] tgt_v;
   assign app_v  = app_insn_i;
   assign trap_v = trap_insn_i;
   assign tgt_v  = pred_target_i;

   // Candidate chain
   logic [WIDTH-1:0][AW-1:0] c_pc, c_nxt_pc, c_nxt_npc;
   logic [WIDTH-1:0][IW-1:0] c_insn;
   logic [WIDTH-1:0][TW-1:0] c_tag;
   logic [WIDTH-1:0]         c_ill, c_live;
   src_e                     c_src [WIDTH];

   for (genvar k = 0; k < WIDTH; k++) begin : g_cand
      dgc_src_sel #(
         .IW       (IW),
         .ILL_WORD (ILL_WORD)
      ) u_src (
         .app_hit_i   (app_hit_i[k]),
         .trap_hit_i  (trap_hit_i[k]),
         .priv_i      (priv_i),
         .app_insn_i  (app_v[k]),
         .trap_insn_i (trap_v[k]),
         .src_o       (c_src[k]),
         .insn_o      (c_insn[k])
      );
      assign c_ill[k] = (c_src[k] == SRC_ILL);
      assign c_tag[k] = tag_q + TW'(k);
   end

   always_comb begin
      logic [AW-1:0] p, n;
      logic          live;
      p    = pc_q;
      n    = npc_q;
      live = !halt_q;
      for (int k = 0; k < WIDTH; k++) begin
         c_pc[k]   = p;
         c_live[k] = live;
         if (pred_taken_i[k] && !c_ill[k]) begin
            p = tgt_v[k];
            n = tgt_v[k] + STEP_V;
         end else begin
            p = n;
            n = n + STEP_V;
         end
         c_nxt_pc[k]  = p;
         c_nxt_npc[k] = n;
         live = live && !c_ill[k] && !pred_taken_i[k];
      end
   end
   assign fetch_pc_o = c_pc;

   // Replay holder
   logic          hold_v, hold_ill, rel, load;
   logic [AW-1:0] hold_pc;
   logic [IW-1:0] hold_insn;
   logic [TW-1:0] hold_tag;
   logic [IDXW-1:0] ld_idx;
   logic [CNTW-1:0] ndec;

   dgc_replay #(.AW(AW), .IW(IW), .TW(TW)) u_replay (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (flush_i),
      .load_i    (load),
      .rel_i     (rel),
      .ld_pc_i   (c_pc[ld_idx]),
      .ld_insn_i (c_insn[ld_idx]),
      .ld_tag_i  (c_tag[ld_idx]),
      .ld_ill_i  (c_ill[ld_idx]),
      .valid_o   (hold_v),
      .pc_o      (hold_pc),
      .insn_o    (hold_insn),
      .tag_o     (hold_tag),
      .ill_o     (hold_ill)
   );
   assign stall_o = hold_v;

   // Slot mapping and dispatch handshake
   logic [WIDTH-1:0][AW-1:0] s_pc;
   logic [WIDTH-1:0][IW-1:0] s_insn;
   logic [WIDTH-1:0][TW-1:0] s_tag;

   dgc_slot_map #(.W(WIDTH), .AW(AW), .IW(IW), .TW(TW)) u_map (
      .gate_i       (rst_n && !flush_i),
      .hold_valid_i (hold_v),
      .hold_pc_i    (hold_pc),
      .hold_insn_i  (hold_insn),
      .hold_tag_i   (hold_tag),
      .hold_ill_i   (hold_ill),
      .c_live_i     (c_live),
      .c_pc_i       (c_pc),
      .c_insn_i     (c_insn),
      .c_tag_i      (c_tag),
      .c_ill_i      (c_ill),
      .accept_i     (disp_accept_i),
      .s_valid_o    (disp_valid_o),
      .s_pc_o       (s_pc),
      .s_insn_o     (s_insn),
      .s_tag_o      (s_tag),
      .s_ill_o      (disp_ill_o),
      .rel_o        (rel),
      .load_o       (load),
      .ld_idx_o     (ld_idx),
      .ndec_o       (ndec)
   );
   assign disp_pc_o   = s_pc;
   assign disp_insn_o = s_insn;
   assign disp_tag_o  = s_tag;

   // Continuation point after the last decoded candidate
   logic [AW-1:0] sel_pc, sel_npc;
   logic          sel_ill;
   always_comb begin
      sel_pc  = pc_q;
      sel_npc = npc_q;
      sel_ill = 1'b0;
      for (int k = 0; k < WIDTH; k++) begin
         if (int'(ndec) == k + 1) begin
            sel_pc  = c_nxt_pc[k];
            sel_npc = c_nxt_npc[k];
            sel_ill = c_ill[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         npc_q  <= RESET_PC + STEP_V;
         tag_q  <= '0;
         halt_q <= 1'b0;
      end else if (flush_i) begin
         pc_q   <= flush_pc_i;
         npc_q  <= flush_npc_i;
         halt_q <= 1'b0;
      end else if (ndec != '0) begin
         pc_q   <= sel_pc;
         npc_q  <= sel_npc;
         tag_q  <= tag_q + TW'(ndec);
         if (sel_ill) halt_q <= 1'b1;
      end
   end

   // Assertions
   for (genvar s = 1; s < WIDTH; s++) begin : g_chk
      AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
         disp_valid_o[s] |-> disp_valid_o[s-1]); // R3
      AST_ILL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
         disp_valid_o[s] |-> !disp_ill_o[s-1]); // R6
      AST_TAG_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
         disp_valid_o[s] |-> (s_tag[s] == s_tag[s-1] + TW'(1))); // R9
   end

   AST_FLUSH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (c_pc[0] == $past(flush_pc_i) && !stall_o)); // R10
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid_o[0] && disp_ill_o[0] && disp_accept_i[0] && !flush_i) |=> (disp_valid_o == '0)); // R6
   AST_STALL_AFTER_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid_o[0] && !disp_accept_i[0] && !flush_i) |=> stall_o); // R2
endmodule

// File: tb/decode_group_ctrl_test.sv
module decode_group_ctrl_test;
   localparam int W  = 3;
   localparam int AW = 16;
   localparam int IW = 32;
   localparam int TW = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   logic              rst_n, flush_i, priv_i;
   logic [AW-1:0]     flush_pc_i, flush_npc_i;
   logic [W*AW-1:0]   fetch_pc_o, pred_target_i, disp_pc_o;
   logic [W-1:0]      app_hit_i, trap_hit_i, pred_taken_i, disp_valid_o, disp_ill_o, acc_i;
   logic [W*IW-1:0]   app_insn_i, trap_insn_i, disp_insn_o;
   logic [W*TW-1:0]   disp_tag_o;
   logic              stall_o;

   decode_group_ctrl #(.WIDTH(W), .AW(AW), .IW(IW), .TW(TW), .STEP(4)) uut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_pc_i(flush_pc_i),
      .flush_npc_i(flush_npc_i), .priv_i(priv_i), .fetch_pc_o(fetch_pc_o),
      .app_hit_i(app_hit_i), .app_insn_i(app_insn_i), .trap_hit_i(trap_hit_i),
      .trap_insn_i(trap_insn_i), .pred_taken_i(pred_taken_i), .pred_target_i(pred_target_i),
      .disp_valid_o(disp_valid_o), .disp_pc_o(disp_pc_o), .disp_insn_o(disp_insn_o),
      .disp_tag_o(disp_tag_o), .disp_ill_o(disp_ill_o), .disp_accept_i(acc_i),
      .stall_o(stall_o)
   );

   // Memory and predictor model: app below 0x100, trap window 0x8000-0x803F,
   // one taken branch at 0x40 towards 0x80
   always_comb begin
      for (int k = 0; k < W; k++) begin
         logic [AW-1:0] a;
         a = fetch_pc_o[k*AW +: AW];
         app_hit_i[k]               = (a < 16'h0100);
         app_insn_i[k*IW +: IW]     = {16'hA5A5, a};
         trap_hit_i[k]              = (a >= 16'h8000) && (a < 16'h8040);
         trap_insn_i[k*IW +: IW]    = {16'h7E7E, a};
         pred_taken_i[k]            = (a == 16'h0040);
         pred_target_i[k*AW +: AW]  = 16'h0080;
      end
   end

   typedef struct packed {
      logic [AW-1:0] pc;
      logic [IW-1:0] insn;
      logic [TW-1:0] tag;
      logic          ill;
   } exp_t;
   exp_t q[$];

   int checks = 0, errors = 0;
   logic [TW-1:0] nxt_tag = '0;
   bit halted = 0, done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Driver: expected program-order stream from a start PC
   task automatic push_run(input logic [AW-1:0] start, input bit priv);
      logic [AW-1:0] p;
      exp_t e;
      p = start;
      for (int i = 0; i < 200; i++) begin
         e.pc = p; e.tag = nxt_tag;
         if (p < 16'h0100) begin e.insn = {16'hA5A5, p}; e.ill = 0; end            // R4
         else if (priv && p >= 16'h8000 && p < 16'h8040) begin e.insn = {16'h7E7E, p}; e.ill = 0; end // R5
         else begin e.insn = '0; e.ill = 1; end                                    // R6
         q.push_back(e);
         nxt_tag = nxt_tag + 1'b1;
         if (e.ill) break;
         p = (p == 16'h0040) ? 16'h0080 : p + 16'd4;                               // R7 R8
      end
   endtask

   // Monitor: pop consumed slots and compare
   always @(negedge clk) begin
      if (rst_n) begin
         logic ok;
         bit   nh;
         exp_t e;
         ok = 1; nh = halted;
         if (halted && disp_valid_o != '0)
            chk(0, "R6", "valid while halted", 64'(disp_valid_o), 64'd0);
         for (int s = 0; s < W; s++) begin
            if (disp_valid_o[s]) begin
               if (s > 0 && disp_valid_o[s] && disp_pc_o[(s-1)*AW +: AW] == 16'h0040 && !disp_ill_o[s-1])
                  chk(0, "R8", "slot after taken branch", 64'(s), 64'd0);
               if (ok && acc_i[s]) begin
                  if (q.size() == 0) chk(0, "R3", "unexpected instruction", 64'(disp_pc_o[s*AW +: AW]), 64'd0);
                  else begin
                     e = q.pop_front();
                     chk(disp_pc_o[s*AW +: AW] == e.pc, "R7", "pc", 64'(disp_pc_o[s*AW +: AW]), 64'(e.pc));
                     chk(disp_insn_o[s*IW +: IW] == e.insn, "R4", "insn", 64'(disp_insn_o[s*IW +: IW]), 64'(e.insn));
                     chk(disp_tag_o[s*TW +: TW] == e.tag, "R9", "tag", 64'(disp_tag_o[s*TW +: TW]), 64'(e.tag));
                     chk(disp_ill_o[s] == e.ill, "R6", "ill flag", 64'(disp_ill_o[s]), 64'(e.ill));
                     if (e.ill) nh = 1;
                  end
               end else ok = 0;
            end
         end
         if (flush_i) nh = 0;
         halted = nh;
      end
   end

   task automatic drain();
      int n = 0;
      while (q.size() != 0 && n < 400) begin @(negedge clk); n++; end
      chk(q.size() == 0, "R3", "stream drained", 64'(q.size()), 64'd0);
   endtask

   task automatic do_flush(input logic [AW-1:0] tgt, input bit priv);
      @(posedge clk); #1;
      if (q.size() != 0) nxt_tag = q[0].tag + (stall_o ? 8'd1 : 8'd0);
      q.delete();
      push_run(tgt, priv);
      flush_i = 1; flush_pc_i = tgt; flush_npc_i = tgt + 16'd4; priv_i = priv; acc_i = '1;
      @(negedge clk);
      chk(disp_valid_o == '0, "R10", "valid during flush", 64'(disp_valid_o), 64'd0);
      @(posedge clk); #1; flush_i = 0;
      @(negedge clk);
      chk(!stall_o, "R10", "holder after flush", 64'(stall_o), 64'd0);
      chk(fetch_pc_o[AW-1:0] == tgt, "R10", "fetch pc after flush", 64'(fetch_pc_o[AW-1:0]), 64'(tgt));
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R3 watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [AW-1:0] hp;
      rst_n = 0; flush_i = 0; priv_i = 0; acc_i = '1;
      flush_pc_i = '0; flush_npc_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(disp_valid_o == '0, "R11", "valid in reset", 64'(disp_valid_o), 64'd0);
      chk(!stall_o, "R11", "stall in reset", 64'(stall_o), 64'd0);
      chk(fetch_pc_o[AW-1:0] == 16'h0, "R11", "reset pc", 64'(fetch_pc_o[AW-1:0]), 64'd0);
      push_run(16'h0000, 0);
      @(posedge clk); #1; rst_n = 1;
      @(negedge clk);
      chk(disp_valid_o == 3'b111, "R3", "full group", 64'(disp_valid_o), 64'h7);
      chk(disp_pc_o == {16'h8, 16'h4, 16'h0}, "R3", "group pcs", 64'(disp_pc_o), 64'h0008_0004_0000);
      // refuse slot 1
      @(posedge clk); #1; acc_i = 3'b001;
      @(negedge clk); hp = disp_pc_o[AW +: AW];
      @(posedge clk); #1; acc_i = 3'b000;
      @(negedge clk);
      chk(stall_o, "R2", "stall after refusal", 64'(stall_o), 64'd1);
      chk(disp_valid_o[0] && disp_pc_o[AW-1:0] == hp, "R1", "replay in slot 0", 64'(disp_pc_o[AW-1:0]), 64'(hp));
      @(posedge clk); #1; acc_i = 3'b110;
      @(negedge clk);
      chk(stall_o && disp_pc_o[AW-1:0] == hp, "R1", "replay held while refused", 64'(disp_pc_o[AW-1:0]), 64'(hp));
      @(posedge clk); #1; acc_i = 3'b111;
      drain();
      repeat (3) begin
         @(negedge clk);
         chk(disp_valid_o == '0, "R6", "quiet after illegal pc", 64'(disp_valid_o), 64'd0);
      end
      // trap-table run in privileged mode
      do_flush(16'h8000, 1);
      drain();
      // flush while the holder is occupied
      do_flush(16'h0000, 0);
      @(posedge clk); #1; acc_i = 3'b001;
      do_flush(16'h0080, 0);
      drain();
      // trap window without privilege gives an illegal pc at once
      do_flush(16'h8000, 0);
      drain();
      done = 1;
      finish_run();
   end
endmodule